// File: doc/BRIEF.md
# Instruction Fetch and Flush Sequencer

This block sits at the front of a small 8-bit controller core that reads 16-bit program words. It splits the oscillator clock into instruction cycles of four phases. It keeps one prefetched word ahead of the instruction being executed, and it hands the core one issued instruction per cycle together with a valid flag. A few opcode patterns mark the first half of a two-word instruction. These patterns come from a mask/match table set by parameters. When the sequencer sees such a word, it inserts one bubble cycle, waits for the following word, and issues both words together as a single 32-bit instruction.

The core reports a taken conditional test or any program-counter change with a one-cycle-wide flush strobe and a target address. The sequencer reloads its program address from the target. It discards the prefetched word, and any half-joined two-word instruction with it, and issues an empty slot in its place. The execution stage therefore sees exactly one NOP cycle per redirect. A word whose top nibble is `1111` is an extension word. If it reaches issue on its own, it is turned into a NOP.

Top module: `ifetch_seq`

## Requirements
- R1: `phase_o` is one-hot. Bit 0 marks the first phase of an instruction cycle, and the active bit moves up by one position on every clock, wrapping from bit 3 back to bit 0.
- R2: While `rst_n` is low, and in the first instruction cycle after its release, `pmem_addr` is 0, `phase_o` is `4'b0001`, `instr_valid` and `instr_wide` are 0, and `instr_o` is 0. The word at address 0 is issued with `instr_valid`=1 in the second cycle after release.
- R3: The sequencer captures `pmem_rdata` on the clock edge that ends the second phase (`phase_o`=`4'b0010`), and `pmem_addr` then increases by one.
- R4: The issued outputs change only on the clock edge that ends the fourth phase. A single-word instruction is issued as `instr_o`={16'h0000, word}, with `instr_valid`=1 and `instr_wide`=0, in the cycle after the cycle in which it was fetched.
- R5: `flush_i` has no effect unless it is high at the clock edge that ends the fourth phase. At any other time, the address keeps stepping and the next instruction is issued normally.
- R6: A flush seen at the end of the fourth phase loads `pmem_addr` with `flush_target`. The next cycle issues a NOP (`instr_valid`=0, `instr_o`=0), and the word at the target is issued in the cycle after that.
- R7: A word matching an entry of the table (default entries, as mask/match: `FF00`/`EF00`, `FE00`/`EC00`, `F000`/`C000`) is followed by one NOP cycle. The sequencer then issues `instr_o`={first word, next word}, with `instr_valid`=1 and `instr_wide`=1.
- R8: A word with bits [15:12]=`1111` that does not follow a table-matching first word is issued as a NOP (`instr_valid`=0, `instr_o`=0).
- R9: A flush during the bubble cycle of a two-word instruction cancels the pending join. The word fetched at the target is then issued as an ordinary single word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pmem_rdata | input | 16 | Program memory read data for `pmem_addr` |
| flush_i | input | 1 | Taken test or PC change; acts at the end of the fourth phase |
| flush_target | input | AW (12) | New program word address on flush |
| pmem_addr | output | AW (12) | Program word address being fetched |
| instr_o | output | 32 | Issued instruction; a single word sits in the low half |
| instr_valid | output | 1 | Issued slot holds a real instruction |
| instr_wide | output | 1 | Issued instruction is a joined two-word form |
| phase_o | output | 4 | One-hot phase of the instruction cycle |

## Verification
The hardest state to reach from the ports is a flush that lands in the bubble cycle of a two-word instruction, because the first word is already latched and waiting for its partner. To get there, the stimulus places a table-matching first word at the end of a run of plain words and raises the flush strobe in the cycle where the issued slot is empty. It then puts an extension-prefixed word right after the target's first word. This layout means a join that was not cancelled appears as a wide instruction one cycle later, and a correctly cancelled join leaves that extension word to become a NOP. The program also sends flushes on a plain word and on a joined two-word instruction, and it pulses the strobe only in the early phases to show that it is ignored there.

// File: rtl/ifetch_pkg.sv
// Package: shared widths, phase indices and the issue-slot type for the
// instruction fetch sequencer. Assumes 16-bit program words.
package ifetch_pkg;
    localparam int WORD_W     = 16;
    localparam int INSTR_W    = 2 * WORD_W;
    localparam int PHASES     = 4;
    localparam int PH_W       = $clog2(PHASES);
    localparam int PH_FETCH   = 1;   // fetch at the close of the second phase
    localparam int PH_ISSUE   = 3;   // issue and flush at the close of the last phase
    localparam int EXT_W      = 4;
    localparam logic [EXT_W-1:0]  EXT_PREFIX = '1;
    localparam logic [WORD_W-1:0] NOP_WORD   = '0;

    typedef struct packed {
        logic               valid;
        logic               wide;
        logic [INSTR_W-1:0] bits;
    } issue_t;

    localparam issue_t EMPTY_SLOT = '{valid: 1'b0, wide: 1'b0, bits: '0};
endpackage

// File: rtl/ifs_phase.sv
// Phase generator: divides the oscillator clock into instruction cycles of
// PHASES clocks, gives a one-hot phase vector and two single-clock ticks.
// Assumes a synchronous active-low reset that starts in the first phase.
module ifs_phase
    import ifetch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [PHASES-1:0] phase_oh,
    output logic              fetch_tick,
    output logic              issue_tick
);
    logic [PH_W-1:0] cnt;

    // Free-running phase counter, wraps every instruction cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    // One decoder per phase.
    for (genvar i = 0; i < PHASES; i++) begin : g_ph
        assign phase_oh[i] = (cnt == PH_W'(i));
    end

    assign fetch_tick = phase_oh[PH_FETCH];
    assign issue_tick = phase_oh[PH_ISSUE];
endmodule

// File: rtl/ifs_pc.sv
// Program address register: steps by one word per fetch, loads a target
// on redirect. Assumes load and advance never arrive on the same clock.
module ifs_pc #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  logic          load,
    input  logic [AW-1:0] target,
    output logic [AW-1:0] pc
);
    // Address update: redirect first, otherwise step on fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)       pc <= '0;
        else if (load)    pc <= target;
        else if (advance) pc <= pc + 1'b1;
    end
endmodule

// File: rtl/ifs_wide_detect.sv
// Word classifier: flags a word that opens a two-word instruction (any
// mask/match table entry hits) and a word carrying the extension prefix.
// Assumes table entries are packed WORD_W slices, entry 0 in the low bits.
module ifs_wide_detect
    import ifetch_pkg::*;
#(
    parameter int                         NUM_WIDE   = 3,
    parameter logic [NUM_WIDE*WORD_W-1:0] WIDE_MASK  = '0,
    parameter logic [NUM_WIDE*WORD_W-1:0] WIDE_MATCH = '0
) (
    input  logic [WORD_W-1:0] word,
    output logic              is_first,
    output logic              is_ext
);
    logic [NUM_WIDE-1:0] hit;

    // One comparator per table entry.
    for (genvar i = 0; i < NUM_WIDE; i++) begin : g_ent
        assign hit[i] = ((word & WIDE_MASK[i*WORD_W +: WORD_W])
                         == WIDE_MATCH[i*WORD_W +: WORD_W]);
    end

    assign is_first = |hit;
    assign is_ext   = (word[WORD_W-1 -: EXT_W] == EXT_PREFIX);
endmodule

// File: rtl/ifetch_seq.sv
// Top: instruction fetch and flush sequencer. Fetches one word per cycle at
// the close of the second phase, issues it at the close of the last phase,
// joins two-word forms behind one bubble and replaces redirected or stray
// slots by NOP. Assumes combinational program memory read by pmem_addr.
module ifetch_seq
    import ifetch_pkg::*;
#(
    parameter int                         AW         = 12,
    parameter int                         NUM_WIDE   = 3,
    parameter logic [NUM_WIDE*WORD_W-1:0] WIDE_MASK  = {16'hF000, 16'hFE00, 16'hFF00},
    parameter logic [NUM_WIDE*WORD_W-1:0] WIDE_MATCH = {16'hC000, 16'hEC00, 16'hEF00}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WORD_W-1:0]  pmem_rdata,
    input  logic               flush_i,
    input  logic [AW-1:0]      flush_target,
    output logic [AW-1:0]      pmem_addr,
    output logic [INSTR_W-1:0] instr_o,
    output logic               instr_valid,
    output logic               instr_wide,
    output logic [PHASES-1:0]  phase_o
);
    logic              fetch_tick, issue_tick;
    logic [WORD_W-1:0] fetch_word;
    logic [WORD_W-1:0] first_word, first_word_nxt;
    logic              join_pend, join_pend_nxt;
    logic              is_first, is_ext;
    issue_t            slot_q, slot_nxt;
    logic              redirect;

    ifs_phase u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_oh   (phase_o),
        .fetch_tick (fetch_tick),
        .issue_tick (issue_tick)
    );

    assign redirect = issue_tick && flush_i;

    ifs_pc #(.AW(AW)) u_pc (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (fetch_tick),
        .load    (redirect),
        .target  (flush_target),
        .pc      (pmem_addr)
    );

    ifs_wide_detect #(
        .NUM_WIDE   (NUM_WIDE),
        .WIDE_MASK  (WIDE_MASK),
        .WIDE_MATCH (WIDE_MATCH)
    ) u_detect (
        .word     (fetch_word),
        .is_first (is_first),
        .is_ext   (is_ext)
    );

    // Prefetch register: captures the addressed word once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)          fetch_word <= NOP_WORD;
        else if (fetch_tick) fetch_word <= pmem_rdata;
    end

    // Next issue slot and join state, decided at the cycle boundary.
    always_comb begin
        slot_nxt       = slot_q;
        join_pend_nxt  = join_pend;
        first_word_nxt = first_word;
        if (issue_tick) begin
            if (flush_i) begin
                slot_nxt      = EMPTY_SLOT;
                join_pend_nxt = 1'b0;
            end else if (join_pend) begin
                slot_nxt      = '{valid: 1'b1, wide: 1'b1, bits: {first_word, fetch_word}};
                join_pend_nxt = 1'b0;
            end else if (is_first) begin
                slot_nxt       = EMPTY_SLOT;
                join_pend_nxt  = 1'b1;
                first_word_nxt = fetch_word;
            end else if (is_ext) begin
                slot_nxt = EMPTY_SLOT;
            end else begin
                slot_nxt = '{valid: 1'b1, wide: 1'b0, bits: {NOP_WORD, fetch_word}};
            end
        end
    end

    // Issue and join registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q     <= EMPTY_SLOT;
            join_pend  <= 1'b0;
            first_word <= NOP_WORD;
        end else begin
            slot_q     <= slot_nxt;
            join_pend  <= join_pend_nxt;
            first_word <= first_word_nxt;
        end
    end

    assign instr_o     = slot_q.bits;
    assign instr_valid = slot_q.valid;
    assign instr_wide  = slot_q.wide;
endmodule

// File: rtl/ifetch_seq_chk.sv
// Checker: temporal properties of the sequencer ports, bound to the top.
// Assumes the reset is held for at least one clock edge.
module ifetch_seq_chk #(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush_i,
    input logic [AW-1:0] flush_target,
    input logic [AW-1:0] pmem_addr,
    input logic [31:0]   instr_o,
    input logic          instr_valid,
    input logic          instr_wide,
    input logic [3:0]    phase_o
);
    logic armed;

    // Marks that one clock has passed since the reset was released.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    a_r1_phase_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> $countones(phase_o) == 1);

    a_r1_phase_rotate: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> phase_o == {$past(phase_o[2:0]), $past(phase_o[3])});

    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && phase_o[1]) |=> pmem_addr == AW'($past(pmem_addr) + 1'b1));

    a_r5_addr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && (phase_o[0] || phase_o[2] || (phase_o[3] && !flush_i)))
        |=> $stable(pmem_addr));

    a_r6_flush_load: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && phase_o[3] && flush_i)
        |=> (pmem_addr == $past(flush_target)) && !instr_valid);

    a_r4_issue_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !phase_o[3])
        |=> $stable(instr_o) && $stable(instr_valid) && $stable(instr_wide));

    a_r7_wide_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && instr_wide) |-> instr_valid);

    a_r8_nop_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !instr_valid) |-> instr_o == 32'h0);
endmodule

bind ifetch_seq ifetch_seq_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (flush_i),
    .flush_target (flush_target),
    .pmem_addr    (pmem_addr),
    .instr_o      (instr_o),
    .instr_valid  (instr_valid),
    .instr_wide   (instr_wide),
    .phase_o      (phase_o)
);

// File: tb/ifetch_seq_bench.sv
// Bench: table of per-cycle stimulus and expectations, then directed tests.
module ifetch_seq_bench;
    localparam int AW   = 12;
    localparam int NROW = 21;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   pmem_rdata;
    logic          flush_i = 1'b0;
    logic [AW-1:0] flush_target = '0;
    logic [AW-1:0] pmem_addr;
    logic [31:0]   instr_o;
    logic          instr_valid, instr_wide;
    logic [3:0]    phase_o;

    logic [15:0] rom [0:63];
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign pmem_rdata = rom[pmem_addr[5:0]];

    ifetch_seq #(.AW(AW)) u_ifetch_seq (
        .clk, .rst_n, .pmem_rdata, .flush_i, .flush_target,
        .pmem_addr, .instr_o, .instr_valid, .instr_wide, .phase_o
    );

    typedef struct packed {
        logic        fl;
        logic [7:0]  tgt;
        logic        v;
        logic        w;
        logic [31:0] ins;
        logic [7:0]  adr;
    } row_t;

    // One row per instruction cycle, observed in its first phase.
    localparam row_t TBL [NROW] = '{
        '{1'b0, 8'd0,  1'b0, 1'b0, 32'h0000_0000, 8'd0},
        '{1'b0, 8'd0,  1'b1, 1'b0, 32'h0000_1234, 8'd1},
        '{1'b0, 8'd0,  1'b1, 1'b0, 32'h0000_2001, 8'd2},
        '{1'b0, 8'd0,  1'b0, 1'b0, 32'h0000_0000, 8'd3},
        '{1'b0, 8'd0,  1'b1, 1'b1, 32'hC011_F022, 8'd4},
        '{1'b0, 8'd0,  1'b1, 1'b0, 32'h0000_3003, 8'd5},
        '{1'b0, 8'd0,  1'b0, 1'b0, 32'h0000_0000, 8'd6},
        '{1'b0, 8'd0,  1'b1, 1'b0, 32'h0000_4004, 8'd7},
        '{1'b0, 8'd0,  1'b0, 1'b0, 32'h0000_0000, 8'd8},
        '{1'b1, 8'd20, 1'b1, 1'b1, 32'hEF10_F000, 8'd9},
        '{1'b0, 8'd0,  1'b0, 1'b0, 32'h0000_0000, 8'd20},
        '{1'b0, 8'd0,  1'b1, 1'b0, 32'h0000_7007, 8'd21},
        '{1'b1, 8'd30, 1'b1, 1'b0, 32'h0000_8008, 8'd22},
        '{1'b0, 8'd0,  1'b0, 1'b0, 32'h0000_0000, 8'd30},
        '{1'b0, 8'd0,  1'b1, 1'b0, 32'h0000_A00A, 8'd31},
        '{1'b0, 8'd0,  1'b1, 1'b0, 32'h0000_B00B, 8'd32},
        '{1'b1, 8'd40, 1'b0, 1'b0, 32'h0000_0000, 8'd33},
        '{1'b0, 8'd0,  1'b0, 1'b0, 32'h0000_0000, 8'd40},
        '{1'b0, 8'd0,  1'b1, 1'b0, 32'h0000_1111, 8'd41},
        '{1'b0, 8'd0,  1'b0, 1'b0, 32'h0000_0000, 8'd42},
        '{1'b0, 8'd0,  1'b1, 1'b0, 32'h0000_2222, 8'd43}
    };

    function automatic string tag_of(int k);
        case (k)
            0:              return "R2";
            3, 4:           return "R7";
            6, 19:          return "R8";
            9, 10, 12, 13:  return "R6";
            16, 17, 18:     return "R9";
            default:        return "R4";
        endcase
    endfunction

    task automatic chk_issue(string tag, logic v, logic w, logic [31:0] ins);
        checks++;
        if (instr_valid !== v || instr_wide !== w || instr_o !== ins) begin
            errors++;
            $display("FAIL %s issue: got v=%b w=%b i=%h, expected v=%b w=%b i=%h",
                     tag, instr_valid, instr_wide, instr_o, v, w, ins);
        end
    endtask

    task automatic chk_addr(string tag, logic [AW-1:0] a);
        checks++;
        if (pmem_addr !== a) begin
            errors++;
            $display("FAIL %s address: got %0d, expected %0d", tag, pmem_addr, a);
        end
    endtask

    task automatic chk_phase(string tag, logic [3:0] p);
        checks++;
        if (phase_o !== p) begin
            errors++;
            $display("FAIL %s phase: got %b, expected %b", tag, phase_o, p);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R2: state while reset is held
        chk_phase("R2", 4'b0001);
        chk_addr("R2", '0);
        chk_issue("R2", 1'b0, 1'b0, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) rom[i] = 16'h0000;
        rom[0]  = 16'h1234; rom[1]  = 16'h2001; rom[2]  = 16'hC011;
        rom[3]  = 16'hF022; rom[4]  = 16'h3003; rom[5]  = 16'hF0AA;
        rom[6]  = 16'h4004; rom[7]  = 16'hEF10; rom[8]  = 16'hF000;
        rom[9]  = 16'h5005; rom[10] = 16'h6006;
        rom[20] = 16'h7007; rom[21] = 16'h8008; rom[22] = 16'hEC05;
        rom[30] = 16'hA00A; rom[31] = 16'hB00B; rom[32] = 16'hEC05;
        rom[33] = 16'hF033;
        rom[40] = 16'h1111; rom[41] = 16'hF0F0; rom[42] = 16'h2222;
        rom[43] = 16'h3333; rom[44] = 16'h4444;

        do_reset();

        // Table walk: one instruction cycle per row, sampled in the first phase.
        for (int k = 0; k < NROW; k++) begin
            chk_issue(tag_of(k), TBL[k].v, TBL[k].w, TBL[k].ins);
            chk_addr((k == 10 || k == 13 || k == 17) ? "R6" : "R3", AW'(TBL[k].adr));
            flush_i      = TBL[k].fl;
            flush_target = AW'(TBL[k].tgt);
            repeat (4) @(negedge clk);
            flush_i = 1'b0;
        end

        // R1, R4, R5: phase walk, issue hold, strobe outside the last phase.
        chk_phase("R1", 4'b0001);
        chk_issue("R4", 1'b1, 1'b0, 32'h0000_3333);
        flush_i = 1'b1;
        flush_target = AW'(50);
        @(negedge clk);
        chk_phase("R1", 4'b0010);
        chk_issue("R4", 1'b1, 1'b0, 32'h0000_3333);
        @(negedge clk);
        chk_phase("R1", 4'b0100);
        flush_i = 1'b0;
        @(negedge clk);
        chk_phase("R1", 4'b1000);
        chk_issue("R4", 1'b1, 1'b0, 32'h0000_3333);
        @(negedge clk);
        chk_phase("R1", 4'b0001);
        chk_addr("R5", AW'(45));
        chk_issue("R5", 1'b1, 1'b0, 32'h0000_4444);

        // R2: reset again mid-run, one NOP cycle, then word 0.
        @(negedge clk);
        do_reset();
        chk_issue("R2", 1'b0, 1'b0, 32'h0);
        chk_addr("R2", '0);
        repeat (4) @(negedge clk);
        chk_issue("R2", 1'b1, 1'b0, 32'h0000_1234);
        chk_addr("R3", AW'(1));

        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            finish_run();
        end
    end
endmodule